// File: doc/BRIEF.md
# Periodic Counter Snapshot Unit

This unit keeps a bank of aggregating event counters. Each counter adds up how many execution units raised its event in a cycle. On a programmable period, or when a manual request arrives, the unit copies every counter in one clock edge. It copies a 64-bit timestamp and a cycle count in the same edge. The result goes out as a report with a fixed layout. The report leaves word by word through a valid/ready write port into a circular buffer. Software drains that buffer later and moves a tail pointer to show its progress.

Counting can span all contexts, or it can be gated so that it runs only while the current context matches a target context. The report format decides how many counters a report carries. A report is only ever written whole. If it would run past the software tail, or if it is triggered while an earlier report is still being written, it is dropped and a sticky overflow flag is raised. The head pointer moves only when a report is complete, so software never sees a partial report.

Write port rules: `wr_valid_o` stays high, and address and data stay unchanged, until `wr_ready_i` is seen high on a rising edge. A word is transferred on each edge where both signals are high. `wr_ready_i` may be held low for any length of time. The counters keep counting while the port is stalled.

Top module: `snap_unit`

## Requirements
- R1: All values in a report are taken in the same cycle. With T the cycle index held in the report's timestamp, each counter word equals the events counted in cycles 0 to T-1 after reset.
- R2: In each counted cycle, counter k increases by the number of execution units that raise event k. Event k of unit u is bit u*NUM_EVT+k of `evt_i`. Several units can add to the same counter in the same cycle.
- R3: A report is laid out as follows. Word 0 is the header: bits 2:0 hold the format, 15:8 the counter count, 23:16 the context present at capture, and 31:24 the reason (1 periodic, 2 manual). Word 1 is the count of counted cycles. Words 2 and 3 are the low and high halves of the free-running 64-bit timestamp, which is 0 in the first cycle after reset. Counter 0 onward follows, one 32-bit word each.
- R4: Format f (3 bits) carries NUM_EVT*(f+1)/8 counters, which is 2 to 16 with the defaults. The report length is that count plus 4 words.
- R5: With `filt_i`=1, events and cycles are counted only in cycles where `ctx_i` equals `tgt_ctx_i`. With `filt_i`=0, every cycle counts.
- R6: With `period_i`=P not 0, periodic reports occur in cycles P-1, 2P-1 and so on after reset, each P cycles after the previous report. With P=0, no periodic report is made.
- R7: A one-cycle `snap_req_i` pulse captures a report in that cycle with reason 2 and restarts the period, so the next periodic report comes P cycles later.
- R8: Report words go out on consecutive addresses modulo the buffer depth, starting at `head_o`. Address and data are held while the port is stalled.
- R9: `head_o` advances by the report length only after the last word of a report is accepted.
- R10: A report is dropped whole, and `ovf_o` is set and stays set until reset, in either of two cases. The first is when its length exceeds DEPTH-1-((head-tail) mod DEPTH). The second is when it is triggered while an earlier report is still being written.
- R11: After reset, `head_o` is 0, `ovf_o` is 0 and `wr_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_UNITS*NUM_EVT | Event pulses, unit-major |
| ctx_i | input | CTX_W | Current context identifier |
| filt_i | input | 1 | 1: count only for the target context |
| tgt_ctx_i | input | CTX_W | Target context for filtered counting |
| period_i | input | PER_W | Snapshot period in cycles, 0 disables |
| fmt_i | input | 3 | Report format select |
| snap_req_i | input | 1 | Manual snapshot request pulse |
| wr_valid_o | output | 1 | Report word valid |
| wr_ready_i | input | 1 | Buffer accepts the word |
| wr_addr_o | output | AW | Buffer word address |
| wr_data_o | output | 32 | Report word |
| head_o | output | AW | Committed write pointer |
| tail_i | input | AW | Software read pointer |
| ovf_o | output | 1 | Sticky report-drop flag |

## Verification
The assertions check the port rules on every cycle. They cover the hold of address and data under a stall, the address step between accepted words, the first word landing at the head, the head moving only as a report completes, and the overflow flag staying set. Only the bench scenarios can show that counter values, the cycle count and the header context match a model indexed by the captured timestamp. The same holds for period spacing, manual restarts, the two filter modes, the counter count for each format, and drops caused by a full buffer or by a trigger while a report is still being written.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int WORD_W    = 32;
  localparam int FMT_W     = 3;
  localparam int PRE_WORDS = 4;   // header, cycle count, timestamp lo, timestamp hi
  localparam int TS_W      = 64;

  typedef enum logic [7:0] {
    RSN_PERIODIC = 8'd1,
    RSN_MANUAL   = 8'd2
  } reason_e;

  // number of counters carried by a given format
  function automatic int unsigned layout_count(input logic [FMT_W-1:0] fmt,
                                               input int unsigned nevt);
    return (nevt * (32'(fmt) + 32'd1)) / 32'd8;
  endfunction
endpackage

// File: rtl/snap_agg.sv
module snap_agg #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_EVT   = 16,
  parameter int CNT_W     = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_UNITS*NUM_EVT-1:0]      evt_i,
  input  logic                              gate_i,
  output logic [NUM_EVT-1:0][CNT_W-1:0]     cnt_o,
  output logic [CNT_W-1:0]                  gclk_o
);
  localparam int INC_W = $clog2(NUM_UNITS + 1);

  genvar e;
  for (e = 0; e < NUM_EVT; e++) begin : g_evt
    logic [INC_W-1:0] inc;
    logic [CNT_W-1:0] acc;

    // population count of this event across all units
    always_comb begin
      inc = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
        inc = inc + INC_W'(evt_i[u*NUM_EVT + e]);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)      acc <= '0;
      else if (gate_i) acc <= acc + CNT_W'(inc);
    end

    assign cnt_o[e] = acc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      gclk_o <= '0;
    else if (gate_i) gclk_o <= gclk_o + 1'b1;
  end
endmodule

// File: rtl/snap_timer.sv
module snap_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  input  logic             man_i,
  output logic             fire_o,
  output logic             manual_o
);
  logic [PER_W-1:0] tmr;
  logic             per_hit;

  assign per_hit  = (period_i != '0) && (tmr >= period_i - 1'b1);
  assign fire_o   = per_hit || man_i;
  assign manual_o = man_i;

  always_ff @(posedge clk) begin
    if (!rst_n)                tmr <= '0;
    else if (fire_o)           tmr <= '0;
    else if (period_i != '0)   tmr <= tmr + 1'b1;
    else                       tmr <= '0;
  end
endmodule

// File: rtl/snap_emit.sv
module snap_emit
  import snap_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int CNT_W   = 32,
  parameter int CTX_W   = 8,
  parameter int AW      = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fire_i,
  input  logic                           manual_i,
  input  logic [FMT_W-1:0]               fmt_i,
  input  logic [CTX_W-1:0]               ctx_i,
  input  logic [NUM_EVT-1:0][CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]               gclk_i,
  input  logic [TS_W-1:0]                ts_i,
  input  logic [AW-1:0]                  tail_i,
  input  logic                           wr_ready_i,
  output logic                           wr_valid_o,
  output logic [AW-1:0]                  wr_addr_o,
  output logic [WORD_W-1:0]              wr_data_o,
  output logic [AW-1:0]                  head_o,
  output logic                           ovf_o
);
  localparam int DEPTH   = 1 << AW;
  localparam int LEN_MAX = NUM_EVT + PRE_WORDS;
  localparam int IDX_W   = $clog2(LEN_MAX + 1);
  localparam int SEL_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic                          busy;
  logic [IDX_W-1:0]              idx, len_q, n_sel, len_sel;
  logic [AW-1:0]                 wptr, head_q, used;
  logic [AW:0]                   free_w;
  logic                          fits, last;
  logic [WORD_W-1:0]             hdr_q, gclk_q;
  logic [TS_W-1:0]               ts_q;
  logic [NUM_EVT-1:0][CNT_W-1:0] shadow;
  logic [IDX_W-1:0]              sel_full;
  logic [SEL_W-1:0]              sel;
  reason_e                       rsn;

  assign n_sel   = IDX_W'(layout_count(fmt_i, NUM_EVT));
  assign len_sel = n_sel + IDX_W'(PRE_WORDS);
  assign used    = head_q - tail_i;
  assign free_w  = (AW+1)'(DEPTH - 1) - {1'b0, used};
  assign fits    = 32'(free_w) >= 32'(len_sel);
  assign last    = (idx == len_q - 1'b1);
  assign rsn     = manual_i ? RSN_MANUAL : RSN_PERIODIC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      len_q  <= '0;
      wptr   <= '0;
      head_q <= '0;
      ovf_q_reset();
    end else begin
      if (busy && wr_ready_i) begin
        idx  <= idx + 1'b1;
        wptr <= wptr + 1'b1;
        if (last) begin
          busy   <= 1'b0;
          head_q <= wptr + 1'b1;
        end
      end
      if (fire_i) begin
        if (busy || !fits) begin
          ovf_o <= 1'b1;
        end else begin
          busy   <= 1'b1;
          idx    <= '0;
          len_q  <= len_sel;
          wptr   <= head_q;
          hdr_q  <= {8'(rsn), 8'(ctx_i), 8'(n_sel), {(8-FMT_W){1'b0}}, fmt_i};
          gclk_q <= WORD_W'(gclk_i);
          ts_q   <= ts_i;
          shadow <= cnt_i;
        end
      end
    end
  end

  // reset helper kept as a plain assignment inside the clocked block
  task automatic ovf_q_reset();
    ovf_o <= 1'b0;
  endtask

  always_comb begin
    sel_full = idx - IDX_W'(PRE_WORDS);
    sel      = SEL_W'(sel_full);
    unique case (idx)
      IDX_W'(0): wr_data_o = hdr_q;
      IDX_W'(1): wr_data_o = gclk_q;
      IDX_W'(2): wr_data_o = ts_q[31:0];
      IDX_W'(3): wr_data_o = ts_q[63:32];
      default:   wr_data_o = (32'(sel_full) < NUM_EVT) ? WORD_W'(shadow[sel]) : '0;
    endcase
  end

  assign wr_valid_o = busy;
  assign wr_addr_o  = wptr;
  assign head_o     = head_q;
endmodule

// File: rtl/snap_unit.sv
module snap_unit
  import snap_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int NUM_EVT   = 16,
  parameter int CTX_W     = 8,
  parameter int PER_W     = 16,
  parameter int AW        = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_UNITS*NUM_EVT-1:0] evt_i,
  input  logic [CTX_W-1:0]             ctx_i,
  input  logic                         filt_i,
  input  logic [CTX_W-1:0]             tgt_ctx_i,
  input  logic [PER_W-1:0]             period_i,
  input  logic [2:0]                   fmt_i,
  input  logic                         snap_req_i,
  output logic                         wr_valid_o,
  input  logic                         wr_ready_i,
  output logic [AW-1:0]                wr_addr_o,
  output logic [31:0]                  wr_data_o,
  output logic [AW-1:0]                head_o,
  input  logic [AW-1:0]                tail_i,
  output logic                         ovf_o
);
  localparam int CNT_W = WORD_W;

  logic                          gate, fire, manual;
  logic [NUM_EVT-1:0][CNT_W-1:0] cnt;
  logic [CNT_W-1:0]              gclk;
  logic [TS_W-1:0]               ts;

  assign gate = !filt_i || (ctx_i == tgt_ctx_i);

  always_ff @(posedge clk) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;
  end

  snap_agg #(.NUM_UNITS(NUM_UNITS), .NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_agg (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .gate_i(gate),
    .cnt_o(cnt), .gclk_o(gclk)
  );

  snap_timer #(.PER_W(PER_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .man_i(snap_req_i),
    .fire_o(fire), .manual_o(manual)
  );

  snap_emit #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W), .CTX_W(CTX_W), .AW(AW)) u_emit (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .manual_i(manual),
    .fmt_i(fmt_i), .ctx_i(ctx_i), .cnt_i(cnt), .gclk_i(gclk), .ts_i(ts),
    .tail_i(tail_i), .wr_ready_i(wr_ready_i), .wr_valid_o(wr_valid_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .head_o(head_o), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/snap_unit_chk.sv
module snap_unit_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [31:0]   wr_data_o,
  input logic [AW-1:0] head_o,
  input logic          ovf_o
);
  // R8: a stalled word keeps its address and data
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  // R8: accepted words step through consecutive addresses
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_ready_i |=> !wr_valid_o || (wr_addr_o == $past(wr_addr_o) + 1'b1));

  // R8: a report starts at the committed head
  p_start_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid_o) |-> wr_addr_o == head_o);

  // R9: head moves only as the final word is taken
  p_head_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (head_o != $past(head_o)) |-> !wr_valid_o && $past(wr_valid_o && wr_ready_i));

  // R10: overflow stays set
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
endmodule

bind snap_unit snap_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
  .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .head_o(head_o), .ovf_o(ovf_o)
);

// File: tb/snap_unit_tb.sv
`timescale 1ns/1ps
module snap_unit_tb;
  localparam int NU = 4, NE = 16, CW = 8, PW = 16, AW = 6;
  localparam int HMAX = 4096;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic [NU*NE-1:0]  evt = '0;
  logic [CW-1:0]     ctx = '0, tgt = '0;
  logic              filt = 1'b0, snap_req = 1'b0, wr_ready = 1'b0;
  logic [PW-1:0]     per = '0;
  logic [2:0]        fmt = '0;
  logic              wr_valid, ovf;
  logic [AW-1:0]     wr_addr, head, tail = '0;
  logic [31:0]       wr_data;

  snap_unit #(.NUM_UNITS(NU), .NUM_EVT(NE), .CTX_W(CW), .PER_W(PW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ctx_i(ctx), .filt_i(filt),
    .tgt_ctx_i(tgt), .period_i(per), .fmt_i(fmt), .snap_req_i(snap_req),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .head_o(head), .tail_i(tail), .ovf_o(ovf)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int unsigned hc [0:HMAX-1][0:NE-1];
  int unsigned hg [0:HMAX-1];
  logic [7:0]  hx [0:HMAX-1];
  int          cyc = 0;
  logic [31:0] mem [0:(1<<AW)-1];

  int  rdy_pct = 100;
  bit  ctx_rand = 0;
  bit  have_last = 0, space_on = 1;
  longint last_ts = 0;
  int  nrep = 0, nman = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // reference history: index c holds the totals at the start of cycle c
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      for (int k = 0; k < NE; k++) hc[0][k] = 0;
      hg[0] = 0;
    end else if (cyc < HMAX-1) begin
      bit g;
      g = !filt || (ctx == tgt);
      hx[cyc] = ctx;
      for (int k = 0; k < NE; k++) begin
        int unsigned n;
        n = 0;
        for (int u = 0; u < NU; u++) n += evt[u*NE + k];
        hc[cyc+1][k] = hc[cyc][k] + (g ? n : 0);
      end
      hg[cyc+1] = hg[cyc] + (g ? 1 : 0);
      cyc++;
    end
    if (rst_n && wr_valid && wr_ready) mem[wr_addr] = wr_data;
  end

  // background stimulus
  always @(negedge clk) begin
    if ($urandom % 16 == 0) evt <= '1;
    else evt <= {$urandom, $urandom} & {$urandom, $urandom};
    if (ctx_rand) ctx <= CW'($urandom % 4);
    wr_ready <= ($urandom % 100) < rdy_pct;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
    summary();
  end

  task automatic parse(inout logic [AW-1:0] tl);
    logic [31:0] w0;
    int     nn, expn, rs;
    longint ts;
    w0   = mem[tl];
    nn   = int'(w0[15:8]);
    rs   = int'(w0[31:24]);
    expn = 2 * (int'(fmt) + 1);
    ts   = {mem[AW'(tl+3)], mem[AW'(tl+2)]};
    nrep++;
    chk(w0[2:0] == fmt, "R4", "format field", w0[2:0], fmt);
    chk(nn == expn, "R4", "counter count", nn, expn);
    chk(rs == 1 || rs == 2, "R3", "reason code", rs, 1);
    if (ts >= cyc) begin
      chk(0, "R1", "timestamp in range", ts, cyc);
    end else begin
      chk(w0[23:16] == hx[ts], "R3", "header context", w0[23:16], hx[ts]);
      chk(mem[AW'(tl+1)] == hg[ts], "R5", "counted cycles", mem[AW'(tl+1)], hg[ts]);
      for (int k = 0; k < expn; k++)
        chk(mem[AW'(tl+4+k)] == hc[ts][k], "R1/R2", "counter value",
            mem[AW'(tl+4+k)], hc[ts][k]);
    end
    if (rs == 2) nman++;
    if (space_on && rs == 1) begin
      if (have_last) chk(ts == last_ts + per, "R6/R7", "period spacing", ts, last_ts + per);
      else           chk(ts == per - 1, "R6", "first periodic", ts, per - 1);
    end
    last_ts   = ts;
    have_last = 1;
    tl = AW'(tl + 4 + expn);
  endtask

  task automatic drain();
    logic [AW-1:0] tl, h;
    tl = tail;
    h  = head;
    while (tl != h) parse(tl);
    tail = tl;
  endtask

  task automatic do_reset();
    rst_n = 0; tail = '0; snap_req = 0; have_last = 0; nman = 0; nrep = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0;
    chk(head == 0, "R11", "head after reset", head, 0);
    chk(ovf == 0, "R11", "ovf after reset", ovf, 0);
    chk(wr_valid == 0, "R11", "valid after reset", wr_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd20241106));
    @(negedge clk);

    // A: all contexts, widest format, random stalls
    fmt = 3'd7; filt = 0; per = 16'd80; rdy_pct = 70; space_on = 1;
    do_reset();
    for (int i = 0; i < 30; i++) begin
      repeat (50) @(negedge clk);
      drain();
    end
    chk(nrep >= 15, "R6", "periodic report count", nrep, 15);
    chk(ovf == 0, "R10", "no overflow with drained buffer", ovf, 0);

    // B: filtered counting, narrow format, manual requests
    fmt = 3'd0; filt = 1; tgt = 8'd3; ctx_rand = 1; per = 16'd64; rdy_pct = 80;
    do_reset();
    begin
      int nreq;
      nreq = 0;
      for (int i = 0; i < 20; i++) begin
        repeat (20) @(negedge clk);
        if (!wr_valid) begin
          snap_req = 1; @(negedge clk); snap_req = 0; nreq++;
        end
        repeat (30) @(negedge clk);
        drain();
      end
      chk(nman == nreq, "R7", "manual report count", nman, nreq);
    end

    // C: period zero, only a manual report
    fmt = 3'd3; filt = 0; ctx_rand = 0; ctx = 8'd9; per = 16'd0; rdy_pct = 100;
    do_reset();
    repeat (300) @(negedge clk);
    chk(head == 0, "R6", "no periodic report when period is 0", head, 0);
    snap_req = 1; @(negedge clk); snap_req = 0;
    repeat (40) @(negedge clk);
    chk(head == 12, "R9", "head after one 12-word report", head, 12);
    drain();
    chk(nman == 1, "R7", "single manual report", nman, 1);

    // D: buffer full, no draining
    fmt = 3'd7; per = 16'd40; rdy_pct = 100; space_on = 0;
    do_reset();
    repeat (250) @(negedge clk);
    chk(head == 60, "R10", "head stops at whole reports", head, 60);
    chk(ovf == 1, "R10", "overflow on full buffer", ovf, 1);
    drain();
    chk(nrep == 3, "R10", "reports kept", nrep, 3);
    repeat (60) @(negedge clk);
    chk(head == 16, "R10", "writing resumes after drain", head, 16);
    chk(ovf == 1, "R10", "overflow sticky", ovf, 1);
    drain();

    // E: trigger while a stalled report is pending
    fmt = 3'd7; per = 16'd10; rdy_pct = 0;
    do_reset();
    repeat (30) @(negedge clk);
    chk(ovf == 1, "R10", "overflow on trigger while busy", ovf, 1);
    chk(head == 0, "R9", "no commit while stalled", head, 0);
    chk(wr_valid == 1, "R8", "valid held under stall", wr_valid, 1);
    rdy_pct = 100;
    repeat (40) @(negedge clk);
    drain();
    chk(nrep >= 1, "R1", "stalled report delivered", nrep, 1);

    summary();
  end
endmodule